// File: doc/BRIEF.md
# Backward State Rewinder for a Three-Register Stream Cipher

This block takes a fully known 288-bit internal state of a three-register nonlinear-feedback stream cipher and runs the cipher backwards, one round per clock. Each backward round shifts the three shift registers down by one place. It then rebuilds the bit that the forward round pushed out of the top of each register, using the feedback equations solved for that bit.

Before every backward round the block tests the state for the layout the cipher has right after key and IV loading. That layout has zeros in the padding of the first two registers, zeros in the bulk of the third register and ones in its top three cells. On a match the block stops. It then presents the 80-bit key, the 80-bit IV and the number of backward rounds it took. A programmable round limit stops a search that finds nothing and flags it as unsuccessful. A new search starts with a single `go` pulse that captures the seed state.

Top module: `trs_rewinder`

## Requirements
- R1: After reset `done` and `not_found` are 0 and `steps_out` is 0.
- R2: A `go` pulse captures `seed_state`, clears `done` and `not_found` and zeroes the round count in the cycle after the pulse. A `go` that arrives while a search runs abandons that search and starts a new one.
- R3: Each clock of a search undoes exactly one forward round. Every register shifts down by one cell. The rebuilt top cells are S92 = S93^S66^S171^(S91&S92), S176 = S177^S162^S264^(S175&S176) and S287 = S0^S243^S69^(S286&S287), all taken from the current state, with bit i of `seed_state` as Si.
- R4: The loaded layout is recognised when S80..S92 are 0, S173..S176 are 0, S177..S284 are 0 and S285..S287 are 1. The test is made before each backward round, so a seed that already matches reports a count of 0.
- R5: On a match `done` rises, `key_out` shows S0..S79 (bit i is Si), `iv_out` shows S93..S172 (bit i is S(93+i)), and `steps_out` equals the number of backward rounds taken.
- R6: If the count equals `max_steps` and the state does not match, `not_found` rises and `steps_out` equals `max_steps`.
- R7: The match test has priority over the limit test, so a match reached after exactly `max_steps` rounds is reported as found.
- R8: After `done` or `not_found` rises, all outputs hold until the next `go`.
- R9: The round counter is CNT_W bits wide, 16 by default, so that searches much longer than 1952 rounds complete with the exact count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start pulse; captures the seed state |
| seed_state | input | 288 | Known cipher state; bit i is cell Si |
| max_steps | input | CNT_W | Round limit of the search |
| key_out | output | 80 | Recovered key, S0..S79 |
| iv_out | output | 80 | Recovered IV, S93..S172 |
| steps_out | output | CNT_W | Backward rounds taken |
| done | output | 1 | Search ended with a match |
| not_found | output | 1 | Search reached the limit without a match |

## Verification
The bench builds the block with the default 16-bit counter. With that width it sweeps every forward distance from 0 to 24 rounds, each with its own random key and IV. It then adds distances of 1152, 1952 and 3000 rounds, which reach well past the usual initialisation and capture window. Because of the 16-bit counter it can also set the limit to exactly the distance, to one less than the distance, and to a value far below it. These cases place the match-before-limit ordering and the not-found path at known cycle counts.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int ST_W   = 288;
    localparam int KEY_W  = 80;
    localparam int IV_W   = 80;
    localparam int NLANES = 3;
    // lane base positions and lengths
    localparam int A_LO  = 0;
    localparam int A_LEN = 93;
    localparam int B_LO  = A_LO + A_LEN;
    localparam int B_LEN = 84;
    localparam int C_LO  = B_LO + B_LEN;
    localparam int C_LEN = 111;
    localparam int IV_LO = B_LO;
    localparam int C_ONES = 3;

    typedef logic [ST_W-1:0] state_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEEK = 2'd1,
        PH_HIT  = 2'd2,
        PH_MISS = 2'd3
    } phase_e;

    function automatic int lane_lo(input int g);
        return (g == 0) ? A_LO : ((g == 1) ? B_LO : C_LO);
    endfunction

    function automatic int lane_len(input int g);
        return (g == 0) ? A_LEN : ((g == 1) ? B_LEN : C_LEN);
    endfunction
endpackage

// File: rtl/trs_back_step.sv
module trs_back_step
    import trs_pkg::*;
(
    input  state_t cur,
    output state_t prev
);
    logic [NLANES-1:0] fb;

    // rebuild the cell each lane discarded in the forward round
    always_comb begin
        fb[0] = cur[93]  ^ cur[66]  ^ cur[171] ^ (cur[91]  & cur[92]);
        fb[1] = cur[177] ^ cur[162] ^ cur[264] ^ (cur[175] & cur[176]);
        fb[2] = cur[0]   ^ cur[243] ^ cur[69]  ^ (cur[286] & cur[287]);
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LO  = lane_lo(g);
        localparam int LEN = lane_len(g);
        assign prev[LO+LEN-2:LO] = cur[LO+LEN-1:LO+1];
        assign prev[LO+LEN-1]    = fb[g];
    end
endmodule

// File: rtl/trs_load_match.sv
module trs_load_match
    import trs_pkg::*;
(
    input  state_t st,
    output logic   hit
);
    logic pad_a_zero, pad_b_zero, body_c_zero, top_c_ones;

    always_comb begin
        pad_a_zero  = ~|st[A_LO+A_LEN-1:A_LO+KEY_W];
        pad_b_zero  = ~|st[B_LO+B_LEN-1:IV_LO+IV_W];
        body_c_zero = ~|st[C_LO+C_LEN-C_ONES-1:C_LO];
        top_c_ones  = &st[ST_W-1:ST_W-C_ONES];
        hit = pad_a_zero & pad_b_zero & body_c_zero & top_c_ones;
    end
endmodule

// File: rtl/trs_rewinder.sv
module trs_rewinder
    import trs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [ST_W-1:0]  seed_state,
    input  logic [CNT_W-1:0] max_steps,
    output logic [KEY_W-1:0] key_out,
    output logic [IV_W-1:0]  iv_out,
    output logic [CNT_W-1:0] steps_out,
    output logic             done,
    output logic             not_found
);
    typedef struct packed {
        state_t           st;
        logic [CNT_W-1:0] cnt;
        phase_e           ph;
    } regs_t;

    regs_t  r_d, r_q;
    state_t prev_st;
    logic   hit;
    logic   at_limit;

    trs_back_step u_step (
        .cur  (r_q.st),
        .prev (prev_st)
    );

    trs_load_match u_match (
        .st  (r_q.st),
        .hit (hit)
    );

    assign at_limit = (r_q.cnt == max_steps);

    always_comb begin
        r_d = r_q;
        if (go) begin
            r_d.st  = seed_state;
            r_d.cnt = '0;
            r_d.ph  = PH_SEEK;
        end else if (r_q.ph == PH_SEEK) begin
            if (hit) begin
                r_d.ph = PH_HIT;
            end else if (at_limit) begin
                r_d.ph = PH_MISS;
            end else begin
                r_d.st  = prev_st;
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= '0;
            r_q.cnt <= '0;
            r_q.ph  <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign key_out   = r_q.st[A_LO+KEY_W-1:A_LO];
    assign iv_out    = r_q.st[IV_LO+IV_W-1:IV_LO];
    assign steps_out = r_q.cnt;
    assign done      = (r_q.ph == PH_HIT);
    assign not_found = (r_q.ph == PH_MISS);

    logic stepping;
    assign stepping = (r_q.ph == PH_SEEK) && !hit && !at_limit && !go;

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && not_found));

    a_r2_go_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (steps_out == '0) && !done && !not_found);

    a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |=> steps_out == ($past(steps_out) + 1'b1));

    a_r3_lane_a_shift: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |=> r_q.st[A_LEN-2:0] == $past(r_q.st[A_LEN-1:1]));

    a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || not_found) && !go) |=> $stable(r_q.st) && $stable(steps_out));

    a_r6_miss_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_found) |-> steps_out == $past(max_steps));

    a_r7_hit_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.ph == PH_SEEK) && hit && !go) |=> done);
endmodule

// File: tb/trs_rewinder_test.sv
module trs_rewinder_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [287:0]  seed_state = '0;
    logic [CW-1:0] max_steps = '1;
    logic [79:0]   key_out, iv_out;
    logic [CW-1:0] steps_out;
    logic          done, not_found;

    int n_chk = 0;
    int n_bad = 0;
    logic [79:0] cur_key, cur_iv;

    always #4 clk = ~clk;

    trs_rewinder #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .seed_state(seed_state),
        .max_steps(max_steps), .key_out(key_out), .iv_out(iv_out),
        .steps_out(steps_out), .done(done), .not_found(not_found)
    );

    function automatic logic [287:0] fwd(input logic [287:0] s);
        logic [287:0] n;
        logic t1, t2, t3;
        t1 = s[65]  ^ (s[90]  & s[91])  ^ s[92]  ^ s[170];
        t2 = s[161] ^ (s[174] & s[175]) ^ s[176] ^ s[263];
        t3 = s[242] ^ (s[285] & s[286]) ^ s[287] ^ s[68];
        n = s;
        n[92:1]    = s[91:0];   n[0]   = t3;
        n[176:94]  = s[175:93]; n[93]  = t1;
        n[287:178] = s[286:177]; n[177] = t2;
        return n;
    endfunction

    function automatic logic [79:0] rnd80();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // build a seed N forward rounds after loading a fresh key and IV
    task automatic make_seed(input int n);
        logic [287:0] s;
        cur_key = rnd80();
        cur_iv  = rnd80();
        s = '0;
        s[79:0]    = cur_key;
        s[172:93]  = cur_iv;
        s[287:285] = 3'b111;
        for (int i = 0; i < n; i++) s = fwd(s);
        seed_state = s;
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic wait_end();
        int t;
        t = 0;
        while (!(done || not_found) && t < 10000) begin
            @(negedge clk); t++;
        end
        if (t >= 10000) begin
            n_chk++; n_bad++;
            $display("FAIL wait: actual busy expected finished");
        end
    endtask

    task automatic run_found(input string req, input int n, input logic [CW-1:0] lim);
        make_seed(n);
        max_steps = lim;
        pulse_go();
        wait_end();
        chk(req, {79'b0, done}, 80'd1);
        chk(req, key_out, cur_key);
        chk(req, iv_out, cur_iv);
        chk(req, {64'b0, steps_out}, 80'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {78'b0, done, not_found}, 80'd0);
        chk("R1", {64'b0, steps_out}, 80'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 sweep of short distances, distance 0 first
        for (int n = 0; n <= 24; n++) run_found("R3/R4/R5", n, '1);

        // R2 flags cleared one cycle after go, following a prior done
        make_seed(10);
        pulse_go();
        chk("R2", {78'b0, done, not_found}, 80'd0);
        chk("R2", {64'b0, steps_out}, 80'd0);
        wait_end();

        // R8 hold after done
        repeat (15) @(negedge clk);
        chk("R8", key_out, cur_key);
        chk("R8", {64'b0, steps_out}, 80'd10);
        chk("R8", {79'b0, done}, 80'd1);

        // R7 limit equal to distance still finds
        run_found("R7", 40, 16'd40);

        // R6 limit one short, and far short
        make_seed(40);
        max_steps = 16'd39;
        pulse_go(); wait_end();
        chk("R6", {78'b0, done, not_found}, 80'd1);
        chk("R6", {64'b0, steps_out}, 80'd39);
        repeat (10) @(negedge clk);
        chk("R8", {78'b0, done, not_found}, 80'd1);
        chk("R8", {64'b0, steps_out}, 80'd39);
        make_seed(300);
        max_steps = 16'd5;
        pulse_go(); wait_end();
        chk("R6", {78'b0, done, not_found}, 80'd1);
        chk("R6", {64'b0, steps_out}, 80'd5);

        // R2 restart while searching
        make_seed(500);
        max_steps = '1;
        pulse_go();
        repeat (20) @(negedge clk);
        chk("R2", {78'b0, done, not_found}, 80'd0);
        run_found("R2", 7, '1);

        // R9 long distances
        run_found("R9", 1152, '1);
        run_found("R9", 1952, '1);
        run_found("R9", 3000, '1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule